// File: doc/BRIEF.md
# Programmed-I/O Strobe Cycle Timer

This block runs one programmed-I/O transfer cycle on a disk-drive channel, counted in bus clocks. A cycle has three phases in a fixed order. First comes the address setup phase with both strobes low. Next is the active phase, with the read or the write strobe asserted. Last is the hold/recovery phase, where the strobes are low again. The length of each phase comes from an 8-bit timing byte. Each field of that byte is a small code that maps to a clock count through a nonlinear table, not a binary count.

Two timing bytes are presented: one for data-port cycles and one for command/control-port cycles. A select input picks one of them when the cycle starts. Both drives on the channel share the same pair of bytes. The timing bytes suited to power-up are 0xF5 for the data port and 0xDE for the command/control ports. These values come from the neighbouring register logic, which drives the timing inputs.

The drive may stretch the active phase through its ready line, but only when ready-stretching is enabled. A bounded wait keeps a silent drive from hanging the channel. There is no data stream through the block, so all pins are plain level or pulse controls with no handshake. A start is a one-clock request that is taken only while the block is idle. A start that arrives while busy is not queued: it is dropped and recorded.

Top module: `ide_pio_timer`

## Requirements
- R1: The setup phase lasts (bits 7:6 of the selected timing byte) + 1 clocks, that is 1, 2, 3 or 4 clocks. During setup `busy_o` is high and both strobes are low.
- R2: The active phase length comes from bits 2:0 of the selected byte: codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks. During the active phase `rd_strobe_o` is high when `write_i` was 0 at start, and `wr_strobe_o` is high when `write_i` was 1. Only one strobe is ever high.
- R3: The hold phase length comes from bits 5:3: codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks. During hold both strobes are low and `busy_o` stays high.
- R4: `done_o` is high for exactly the last clock of the hold phase. `busy_o` is low in the following clock.
- R5: With `cmd_sel_i` = 0 the cycle uses `data_timing_i`; with `cmd_sel_i` = 1 it uses `cmd_timing_i`. At the power-up values, a data cycle (0xF5) has an 8-clock strobe and a command cycle (0xDE) has a 12-clock strobe. Each lasts 20 busy clocks.
- R6: The timing byte, `write_i` and `cmd_sel_i` are captured on the clock that accepts a start. Changing them during a cycle changes only later cycles.
- R7: With `iordy_en_i` = 0, `iordy_i` has no effect on any output.
- R8: With `iordy_en_i` = 1, a low `iordy_i` in the final active clock repeats that clock. The strobe stays high until `iordy_i` is seen high.
- R9: The wait adds at most 255 clocks. If `iordy_i` is still low after 255 extra clocks, the active phase ends and `timeout_o` is set. `timeout_o` stays set until the next accepted start clears it.
- R10: A start while `busy_o` is high is ignored and sets `overrun_o`. `overrun_o` stays set until reset.
- R11: During reset all outputs are low.
- R12: A start while `busy_o` is low is accepted, and `busy_o` is high from the next clock. One start yields exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock cycle request |
| write_i | input | 1 | 1 = write strobe, 0 = read strobe |
| cmd_sel_i | input | 1 | 1 = command/control timing, 0 = data timing |
| data_timing_i | input | 8 | Data-port timing byte (setup 7:6, hold 5:3, active 2:0) |
| cmd_timing_i | input | 8 | Command/control timing byte, same layout |
| iordy_en_i | input | 1 | Allow the drive to stretch the active phase |
| iordy_i | input | 1 | Drive ready line, already synchronous |
| rd_strobe_o | output | 1 | Read strobe, high during active phase of a read |
| wr_strobe_o | output | 1 | Write strobe, high during active phase of a write |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | Last clock of the hold phase |
| timeout_o | output | 1 | Ready wait ran out in the last cycle |
| overrun_o | output | 1 | A start was dropped while busy (sticky) |

## Verification
Some properties hold on every clock and are checked by assertions. The strobe direction stays fixed while the strobe is high. Every falling strobe is followed by a hold clock. Each done pulse is followed by idle, and `busy_o` only falls after a done pulse. The ready wait count only grows in the final active clock. A timeout only rises after the wait has reached its limit. The overrun flag rises only after a start while busy, and it never clears on its own. Other behaviour needs the bench's scenarios, run against a clock-by-clock reference model. These are the exact phase lengths for every code in the nonlinear tables, the choice between the two timing bytes, and the capture of the byte at start. The stretched strobe, and the 255-clock limit with the timeout being cleared, are also checked this way.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } pio_phase_e;

  // address setup: linear code plus one
  function automatic logic [LEN_W-1:0] setup_clocks(input logic [1:0] code);
    return LEN_W'(code) + LEN_W'(1);
  endfunction

  // recovery after the strobe: linear to six, then 8 and 12
  function automatic logic [LEN_W-1:0] hold_clocks(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd6:    n = LEN_W'(8);
      3'd7:    n = LEN_W'(12);
      default: n = LEN_W'(code) + LEN_W'(1);
    endcase
    return n;
  endfunction

  // strobe width: code plus two up to six, then 8, 12, 16
  function automatic logic [LEN_W-1:0] active_clocks(input logic [2:0] code);
    logic [LEN_W-1:0] n;
    case (code)
      3'd5:    n = LEN_W'(8);
      3'd6:    n = LEN_W'(12);
      3'd7:    n = LEN_W'(16);
      default: n = LEN_W'(code) + LEN_W'(2);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import ide_pio_pkg::*;
(
  input  logic [7:0]       tbyte_i,
  output logic [LEN_W-1:0] setup_len_o,
  output logic [LEN_W-1:0] active_len_o,
  output logic [LEN_W-1:0] hold_len_o
);

  always_comb begin
    setup_len_o  = setup_clocks(tbyte_i[7:6]);
    hold_len_o   = hold_clocks(tbyte_i[5:3]);
    active_len_o = active_clocks(tbyte_i[2:0]);
  end

endmodule

// File: rtl/pio_ready_wait.sv
module pio_ready_wait #(
  parameter int WAIT_MAX = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic last_active_i,
  input  logic iordy_en_i,
  input  logic iordy_i,
  output logic stretch_o,
  output logic timeout_o
);

  localparam int WAIT_W = $clog2(WAIT_MAX + 1);
  localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(WAIT_MAX);

  logic [WAIT_W-1:0] wait_q;
  logic              drive_holds;
  logic              limit_hit;

  assign drive_holds = last_active_i && iordy_en_i && !iordy_i;
  assign limit_hit   = (wait_q == WAIT_LIMIT);
  assign stretch_o   = drive_holds && !limit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q    <= '0;
      timeout_o <= 1'b0;
    end else begin
      if (stretch_o)
        wait_q <= wait_q + WAIT_W'(1);
      else
        wait_q <= '0;

      if (clear_i)
        timeout_o <= 1'b0;
      else if (drive_holds && limit_hit)
        timeout_o <= 1'b1;
    end
  end

  // R9: timeout only after the full extra wait
  a_r9_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(wait_q) == WAIT_LIMIT));

  // R8: extra clocks only accumulate in the final active clock
  a_r8_wait_in_last_active: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != '0) |-> $past(last_active_i));

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import ide_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             write_i,
  input  logic [LEN_W-1:0] setup_len_i,
  input  logic [LEN_W-1:0] active_len_i,
  input  logic [LEN_W-1:0] hold_len_i,
  input  logic             stretch_i,
  output pio_phase_e       phase_o,
  output logic             last_active_o,
  output logic             done_o,
  output logic             rd_o,
  output logic             wr_o
);

  pio_phase_e       phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] act_q;
  logic [LEN_W-1:0] hold_q;
  logic             write_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      hold_q  <= '0;
      write_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept_i) begin
            phase_q <= PH_SETUP;
            cnt_q   <= setup_len_i - LEN_W'(1);
            act_q   <= active_len_i;
            hold_q  <= hold_len_i;
            write_q <= write_i;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= act_q - LEN_W'(1);
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        PH_ACTIVE: begin
          if (cnt_zero) begin
            if (!stretch_i) begin
              phase_q <= PH_HOLD;
              cnt_q   <= hold_q - LEN_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero)
            phase_q <= PH_IDLE;
          else
            cnt_q <= cnt_q - LEN_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o       = phase_q;
  assign last_active_o = (phase_q == PH_ACTIVE) && cnt_zero;
  assign done_o        = (phase_q == PH_HOLD) && cnt_zero;
  assign rd_o          = (phase_q == PH_ACTIVE) && !write_q;
  assign wr_o          = (phase_q == PH_ACTIVE) && write_q;

  // R2: the direction of a strobe never flips while it is high
  a_r2_strobe_direction: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_o || wr_o) && $past(rd_o || wr_o)) |-> $stable(wr_o));

  // R3: a falling strobe is always followed by hold
  a_r3_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_o || wr_o) |-> (phase_o == PH_HOLD));

  // R4: done is the final clock of the cycle
  a_r4_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (phase_o == PH_IDLE));

  // R12: an accepted start always opens a setup phase
  a_r12_accept_to_setup: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (phase_o == PH_SETUP));

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int WAIT_MAX = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       write_i,
  input  logic       cmd_sel_i,
  input  logic [7:0] data_timing_i,
  input  logic [7:0] cmd_timing_i,
  input  logic       iordy_en_i,
  input  logic       iordy_i,
  output logic       rd_strobe_o,
  output logic       wr_strobe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic       overrun_o
);

  logic [7:0]       sel_byte;
  logic [LEN_W-1:0] setup_len;
  logic [LEN_W-1:0] active_len;
  logic [LEN_W-1:0] hold_len;
  logic             accept;
  logic             last_active;
  logic             stretch;
  pio_phase_e       phase;

  assign sel_byte = cmd_sel_i ? cmd_timing_i : data_timing_i;
  assign busy_o   = (phase != PH_IDLE);
  assign accept   = start_i && !busy_o;

  pio_timing_decode u_decode (
    .tbyte_i      (sel_byte),
    .setup_len_o  (setup_len),
    .active_len_o (active_len),
    .hold_len_o   (hold_len)
  );

  pio_phase_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept),
    .write_i       (write_i),
    .setup_len_i   (setup_len),
    .active_len_i  (active_len),
    .hold_len_i    (hold_len),
    .stretch_i     (stretch),
    .phase_o       (phase),
    .last_active_o (last_active),
    .done_o        (done_o),
    .rd_o          (rd_strobe_o),
    .wr_o          (wr_strobe_o)
  );

  pio_ready_wait #(
    .WAIT_MAX (WAIT_MAX)
  ) u_wait (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (accept),
    .last_active_i (last_active),
    .iordy_en_i    (iordy_en_i),
    .iordy_i       (iordy_i),
    .stretch_o     (stretch),
    .timeout_o     (timeout_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      overrun_o <= 1'b0;
    else if (start_i && busy_o)
      overrun_o <= 1'b1;
  end

  // R10: overrun never clears outside reset
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R10: overrun rises only after a start while busy
  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(start_i && busy_o));

  // R4: busy only drops after a done pulse
  a_r4_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

endmodule

// File: tb/ide_pio_timer_test.sv
module ide_pio_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       write_i = 1'b0;
  logic       cmd_sel_i = 1'b0;
  logic [7:0] data_timing_i = 8'hF5;
  logic [7:0] cmd_timing_i = 8'hDE;
  logic       iordy_en_i = 1'b0;
  logic       iordy_i = 1'b1;
  logic       rd_strobe_o, wr_strobe_o, busy_o, done_o, timeout_o, overrun_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ide_pio_timer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
    .cmd_sel_i(cmd_sel_i), .data_timing_i(data_timing_i),
    .cmd_timing_i(cmd_timing_i), .iordy_en_i(iordy_en_i), .iordy_i(iordy_i),
    .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .overrun_o(overrun_o)
  );

  int act_tab[8]  = '{2, 3, 4, 5, 6, 8, 12, 16};
  int hold_tab[8] = '{1, 2, 3, 4, 5, 6, 8, 12};

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase number and clocks left in it
  int m_ph = 0, m_left = 0, m_wait = 0, m_act = 0, m_hold = 0;
  bit m_wr = 0, m_to = 0, m_ov = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_wait = 0; m_wr = 0; m_to = 0; m_ov = 0;
    end else begin
      logic [7:0] b;
      if (start_i && m_ph != 0) m_ov = 1;
      case (m_ph)
        0: if (start_i) begin
             b = cmd_sel_i ? cmd_timing_i : data_timing_i;
             m_ph = 1; m_left = int'(b[7:6]) + 1;
             m_act = act_tab[b[2:0]]; m_hold = hold_tab[b[5:3]];
             m_wr = write_i; m_to = 0;
           end
        1: if (m_left == 1) begin m_ph = 2; m_left = m_act; m_wait = 0; end
           else m_left--;
        2: if (m_left == 1) begin
             if (iordy_en_i && !iordy_i) begin
               if (m_wait < 255) m_wait++;
               else begin m_to = 1; m_ph = 3; m_left = m_hold; end
             end else begin m_ph = 3; m_left = m_hold; end
           end else m_left--;
        default: if (m_left == 1) m_ph = 0; else m_left--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check_bit("R11", "reset busy", busy_o, 1'b0);
      check_bit("R11", "reset strobes", rd_strobe_o | wr_strobe_o, 1'b0);
      check_bit("R11", "reset flags", done_o | timeout_o | overrun_o, 1'b0);
    end else begin
      check_bit("R12", "busy", busy_o, m_ph != 0);
      check_bit("R2", "rd strobe", rd_strobe_o, m_ph == 2 && !m_wr);
      check_bit("R2", "wr strobe", wr_strobe_o, m_ph == 2 && m_wr);
      check_bit("R4", "done", done_o, m_ph == 3 && m_left == 1);
      check_bit("R9", "timeout", timeout_o, m_to);
      check_bit("R10", "overrun", overrun_o, m_ov);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R12 watchdog: cycles %0d expected below %0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // one cycle: returns strobe clocks and busy clocks
  task automatic run_pio(input logic wr, input logic sel, input bit swap,
                         input logic [7:0] swap_byte, output int width, output int total);
    @(negedge clk);
    start_i = 1'b1; write_i = wr; cmd_sel_i = sel;
    @(negedge clk);
    start_i = 1'b0;
    if (swap) begin data_timing_i = swap_byte; write_i = ~wr; cmd_sel_i = ~sel; end
    width = 0; total = 0;
    while (busy_o) begin
      total++;
      if (rd_strobe_o | wr_strobe_o) width++;
      @(negedge clk);
    end
  endtask

  initial begin
    int w, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: power-up timing bytes on each port
    run_pio(1'b0, 1'b0, 0, 8'h00, w, t);
    check_int("R5", "data strobe width", w, 8);
    check_int("R5", "data busy clocks", t, 20);
    run_pio(1'b1, 1'b1, 0, 8'h00, w, t);
    check_int("R5", "cmd strobe width", w, 12);
    check_int("R5", "cmd busy clocks", t, 20);

    // R1 R2 R3: sweep every code of each field
    for (int i = 0; i < 8; i++) begin
      data_timing_i = {2'(i), 3'(7 - i), 3'(i)};
      run_pio(1'(i), 1'b0, 0, 8'h00, w, t);
      check_int("R2", "active width", w, act_tab[i]);
      check_int("R3", "total data", t, (i % 4) + 1 + act_tab[i] + hold_tab[7 - i]);
      cmd_timing_i = {2'(i + 1), 3'(i), 3'(7 - i)};
      run_pio(1'(~i), 1'b1, 0, 8'h00, w, t);
      check_int("R2", "cmd active width", w, act_tab[7 - i]);
      check_int("R1", "total cmd", t, ((i + 1) % 4) + 1 + act_tab[7 - i] + hold_tab[i]);
    end

    // R6: byte changed right after start has no effect on this cycle
    data_timing_i = 8'h00;
    run_pio(1'b0, 1'b0, 1, 8'hFF, w, t);
    check_int("R6", "width with old byte", w, 2);
    check_int("R6", "total with old byte", t, 4);
    run_pio(1'b0, 1'b0, 0, 8'h00, w, t);
    check_int("R6", "new byte next cycle", t, 4 + 16 + 12);

    // R7: ready low but stretching disabled
    data_timing_i = 8'h00; iordy_en_i = 1'b0; iordy_i = 1'b0;
    run_pio(1'b0, 1'b0, 0, 8'h00, w, t);
    check_int("R7", "width ignoring ready", w, 2);
    check_bit("R7", "no timeout", timeout_o, 1'b0);

    // R8: stretch by four clocks
    iordy_en_i = 1'b1;
    @(negedge clk); start_i = 1'b1; write_i = 1'b0; cmd_sel_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    w = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (rd_strobe_o) w++;
    end
    iordy_i = 1'b1;
    while (busy_o) @(negedge clk);
    check_int("R8", "stretched width", w, 6);
    check_bit("R8", "no timeout", timeout_o, 1'b0);

    // R9: ready held low, wait limit reached
    iordy_i = 1'b0;
    run_pio(1'b1, 1'b0, 0, 8'h00, w, t);
    check_int("R9", "limited width", w, 2 + 255);
    check_bit("R9", "timeout set", timeout_o, 1'b1);
    iordy_i = 1'b1;
    run_pio(1'b0, 1'b0, 0, 8'h00, w, t);
    check_bit("R9", "timeout cleared", timeout_o, 1'b0);
    check_int("R9", "normal width", w, 2);

    // R10: start while busy
    data_timing_i = 8'hF5;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    t = 5;
    while (busy_o) begin t++; @(negedge clk); end
    check_int("R10", "ignored start keeps length", t - 1, 20);
    check_bit("R10", "overrun set", overrun_o, 1'b1);
    repeat (5) @(negedge clk);
    check_bit("R12", "idle after single cycle", busy_o, 1'b0);
    check_bit("R10", "overrun sticky", overrun_o, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule